// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block holds the comparison side of four debug breakpoint slots. Each cycle it takes at most one access: an instruction fetch address, a data memory access or an I/O port access. It tests that access against the four slot addresses, using the type, length and enable fields packed into a 32-bit control word. One cycle later it reports which slots matched. It also reports whether the status register should take the new hit bits, and whether a debug exception is wanted.

Instruction slots need an exact address match. Data and I/O slots use an inclusive range-overlap test between the accessed bytes and the slot's covered bytes. For instruction and data checks, a slot records a hit even when it is disabled, so software can see it. Only an enabled hit, or an explicit force request, asks for the status write, and only an enabled hit requests the exception. An I/O check considers enabled I/O slots only. On a hit it reports the address of the following instruction as the resume point.

Top module: `bp_match_unit`

## Requirements
- R1: Slot i (0..3) is enabled when control bit 2i (local) or control bit 2i+1 (global) is set; either bit alone is enough.
- R2: Slot i's kind is control bits [17+4i:16+4i]: 00 instruction, 01 data write, 10 I/O read/write, 11 data read/write.
- R3: Slot i's length code is control bits [19+4i:18+4i]. Code 0 covers 1 byte, 1 covers 2 bytes, 2 covers 8 bytes and 3 covers 4 bytes, starting at the slot address.
- R4: An instruction check (ip_valid) matches a slot of kind 00 exactly when the slot address equals `ip`.
- R5: A data check matches a kind-11 slot for any access and a kind-01 slot only when `d_write` is 1. A match also needs d_addr + d_size - 1 >= slot address and d_addr <= slot address + length - 1, evaluated without wraparound.
- R6: An I/O check matches only enabled kind-10 slots, using the same inclusive overlap test with `io_port` (zero-extended) and `io_size`.
- R7: After an instruction or data check, `hit_vec` bit i is 1 for every matching slot, enabled or not. `status_wr` is 1 when some matching slot is enabled or `force_upd` is 1. `dbg_req` is 1 only when some matching slot is enabled. `resume_ip` equals `ip`.
- R8: After an I/O check, `hit_vec` is the hit mask, and `status_wr` and `dbg_req` are both 1 when that mask is nonzero and both 0 otherwise. On a hit `resume_ip` equals `next_ip`.
- R9: Results appear on the outputs one clock edge after the valid input. A cycle with no valid input yields `hit_vec`=0, `status_wr`=0, `dbg_req`=0 and `resume_ip`=0 on the next cycle.
- R10: When several valid inputs are high together, only one class is checked: instruction first, then data, then I/O.
- R11: While `rst` is high, all outputs are driven to zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 32 | Enable, kind and length fields for all slots |
| slot_addr | input | 128 | Four 32-bit slot addresses, slot i at bits [32i+31:32i] |
| ip | input | 32 | Current instruction address |
| ip_valid | input | 1 | Run an instruction check this cycle |
| next_ip | input | 32 | Address of the following instruction |
| force_upd | input | 1 | Request a status write on an instruction or data check |
| d_addr | input | 32 | Data access start address |
| d_size | input | 4 | Data access size in bytes (1..8) |
| d_write | input | 1 | Data access is a write |
| d_valid | input | 1 | Run a data check this cycle |
| io_port | input | 16 | I/O port number |
| io_size | input | 3 | I/O access size in bytes (1..4) |
| io_valid | input | 1 | Run an I/O check this cycle |
| hit_vec | output | 4 | Matching slots, low status bits to write |
| status_wr | output | 1 | Status should take `hit_vec` |
| dbg_req | output | 1 | Debug exception request |
| resume_ip | output | 32 | Instruction address reported with the result |

## Verification
The instruction, data and I/O strobes can all be asserted in the same cycle. When that happens, only the highest-priority class may be checked. The bench provokes this constantly by drawing all three valid bits and the force bit at random across a narrow address window, so that hits on every class are frequent. Each result is judged against an arithmetic model that applies the instruction-then-data-then-I/O order. A directed case raises all three strobes at once and checks that `resume_ip` shows the instruction address rather than `next_ip`.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    localparam int NSLOT        = 4;
    localparam int AW           = 32;
    localparam int PW           = 16;
    localparam int DSW          = 4;
    localparam int ISW          = 3;
    localparam int CW           = 32;
    localparam int LENW         = 4;
    localparam int KIND_BASE    = 16;
    localparam int LEN_BASE     = 18;
    localparam int FIELD_STRIDE = 4;

    typedef enum logic [1:0] {
        KIND_INSN = 2'b00,
        KIND_DWR  = 2'b01,
        KIND_IO   = 2'b10,
        KIND_DRW  = 2'b11
    } slot_kind_e;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_INSN,
        CLS_DATA,
        CLS_IO
    } acc_class_e;

    typedef struct packed {
        logic             en;
        slot_kind_e       kind;
        logic [LENW-1:0]  nbytes;
    } slot_cfg_t;

    // length code 2 covers eight bytes, every other code c covers c+1
    function automatic logic [LENW-1:0] len_decode(input logic [1:0] code);
        if (code == 2'b10)
            return LENW'(8);
        return LENW'(code) + LENW'(1);
    endfunction

endpackage

// File: rtl/bp_slot_decode.sv
module bp_slot_decode
    import bpm_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [CW-1:0] ctrl,
    output slot_cfg_t     cfg
);
    localparam int EN_LO  = 2 * IDX;
    localparam int KIND_LO = KIND_BASE + FIELD_STRIDE * IDX;
    localparam int LEN_LO  = LEN_BASE + FIELD_STRIDE * IDX;

    always_comb begin
        cfg.en     = ctrl[EN_LO] | ctrl[EN_LO + 1];
        cfg.kind   = slot_kind_e'(ctrl[KIND_LO +: 2]);
        cfg.nbytes = len_decode(ctrl[LEN_LO +: 2]);
    end
endmodule

// File: rtl/bp_range_cmp.sv
module bp_range_cmp #(
    parameter int AW   = 32,
    parameter int LW_A = 4,
    parameter int LW_B = 4
) (
    input  logic [AW-1:0]   a_base,
    input  logic [LW_A-1:0] a_len,
    input  logic [AW-1:0]   b_base,
    input  logic [LW_B-1:0] b_len,
    output logic            overlap
);
    localparam int W = AW + 1;

    logic [W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo = {1'b0, a_base};
        b_lo = {1'b0, b_base};
        a_hi = a_lo + W'(a_len) - W'(1);
        b_hi = b_lo + W'(b_len) - W'(1);
        overlap = (a_hi >= b_lo) && (a_lo <= b_hi);
    end
endmodule

// File: rtl/bp_slot_match.sv
module bp_slot_match
    import bpm_pkg::*;
(
    input  slot_cfg_t        cfg,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    ip,
    input  logic [AW-1:0]    d_addr,
    input  logic [DSW-1:0]   d_size,
    input  logic             d_write,
    input  logic [PW-1:0]    io_port,
    input  logic [ISW-1:0]   io_size,
    output logic             m_insn,
    output logic             m_data,
    output logic             m_io
);
    logic data_ovl;
    logic io_ovl;

    bp_range_cmp #(.AW(AW), .LW_A(DSW), .LW_B(LENW)) u_data_cmp (
        .a_base (d_addr),
        .a_len  (d_size),
        .b_base (base),
        .b_len  (cfg.nbytes),
        .overlap(data_ovl)
    );

    bp_range_cmp #(.AW(AW), .LW_A(ISW), .LW_B(LENW)) u_io_cmp (
        .a_base (AW'(io_port)),
        .a_len  (io_size),
        .b_base (base),
        .b_len  (cfg.nbytes),
        .overlap(io_ovl)
    );

    always_comb begin
        m_insn = (cfg.kind == KIND_INSN) && (base == ip);
        unique case (cfg.kind)
            KIND_DWR: m_data = data_ovl && d_write;
            KIND_DRW: m_data = data_ovl;
            default:  m_data = 1'b0;
        endcase
        m_io = cfg.en && (cfg.kind == KIND_IO) && io_ovl;
    end
endmodule

// File: rtl/bp_match_unit.sv
module bp_match_unit
    import bpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CW-1:0]       ctrl,
    input  logic [NSLOT*AW-1:0] slot_addr,
    input  logic [AW-1:0]       ip,
    input  logic                ip_valid,
    input  logic [AW-1:0]       next_ip,
    input  logic                force_upd,
    input  logic [AW-1:0]       d_addr,
    input  logic [DSW-1:0]      d_size,
    input  logic                d_write,
    input  logic                d_valid,
    input  logic [PW-1:0]       io_port,
    input  logic [ISW-1:0]      io_size,
    input  logic                io_valid,
    output logic [NSLOT-1:0]    hit_vec,
    output logic                status_wr,
    output logic                dbg_req,
    output logic [AW-1:0]       resume_ip
);
    slot_cfg_t        cfg   [NSLOT];
    logic [NSLOT-1:0] en_vec;
    logic [NSLOT-1:0] m_insn, m_data, m_io;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        bp_slot_decode #(.IDX(s)) u_dec (
            .ctrl(ctrl),
            .cfg (cfg[s])
        );

        bp_slot_match u_match (
            .cfg    (cfg[s]),
            .base   (slot_addr[s*AW +: AW]),
            .ip     (ip),
            .d_addr (d_addr),
            .d_size (d_size),
            .d_write(d_write),
            .io_port(io_port),
            .io_size(io_size),
            .m_insn (m_insn[s]),
            .m_data (m_data[s]),
            .m_io   (m_io[s])
        );

        assign en_vec[s] = cfg[s].en;
    end

    acc_class_e       cls;
    logic [NSLOT-1:0] nx_hits;
    logic             nx_wr, nx_dbg;
    logic [AW-1:0]    nx_resume;

    always_comb begin
        if (ip_valid)      cls = CLS_INSN;
        else if (d_valid)  cls = CLS_DATA;
        else if (io_valid) cls = CLS_IO;
        else               cls = CLS_NONE;
    end

    always_comb begin
        nx_hits   = '0;
        nx_wr     = 1'b0;
        nx_dbg    = 1'b0;
        nx_resume = '0;
        unique case (cls)
            CLS_INSN, CLS_DATA: begin
                nx_hits   = (cls == CLS_INSN) ? m_insn : m_data;
                nx_dbg    = |(nx_hits & en_vec);
                nx_wr     = nx_dbg | force_upd;
                nx_resume = ip;
            end
            CLS_IO: begin
                nx_hits   = m_io;
                nx_dbg    = |m_io;
                nx_wr     = nx_dbg;
                nx_resume = nx_dbg ? next_ip : '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_vec   <= '0;
            status_wr <= 1'b0;
            dbg_req   <= 1'b0;
            resume_ip <= '0;
        end else begin
            hit_vec   <= nx_hits;
            status_wr <= nx_wr;
            dbg_req   <= nx_dbg;
            resume_ip <= nx_resume;
        end
    end
endmodule

// File: rtl/bp_match_chk.sv
module bp_match_chk
    import bpm_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [CW-1:0]       ctrl,
    input logic [AW-1:0]       ip,
    input logic                ip_valid,
    input logic [AW-1:0]       next_ip,
    input logic                force_upd,
    input logic                d_valid,
    input logic                io_valid,
    input logic [NSLOT-1:0]    hit_vec,
    input logic                status_wr,
    input logic                dbg_req,
    input logic [AW-1:0]       resume_ip
);
    logic [NSLOT-1:0] en_mask, insn_kind_mask;

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            en_mask[s]        = ctrl[2*s] | ctrl[2*s+1];
            insn_kind_mask[s] = ctrl[KIND_BASE + FIELD_STRIDE*s +: 2] == 2'b00;
        end
    end

    // R7 / R8: an exception request always comes with a status write
    a_r7_dbg_with_wr: assert property (@(posedge clk) disable iff (rst)
        dbg_req |-> status_wr);

    // R7: an exception needs an enabled slot among the hits
    a_r7_dbg_enabled: assert property (@(posedge clk) disable iff (rst)
        ip_valid |=> (!dbg_req || ((hit_vec & $past(en_mask)) != '0)));

    // R7: force always yields a status write on an instruction check
    a_r7_force_wr: assert property (@(posedge clk) disable iff (rst)
        (ip_valid && force_upd) |=> status_wr);

    // R9: an idle cycle leaves the outputs quiet
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ip_valid && !d_valid && !io_valid) |=>
            (!status_wr && !dbg_req && hit_vec == '0));

    // R10: the instruction class wins and reports its own address
    a_r10_insn_first: assert property (@(posedge clk) disable iff (rst)
        ip_valid |=> resume_ip == $past(ip));

    // R4: instruction hits only on instruction-kind slots
    a_r4_insn_kind: assert property (@(posedge clk) disable iff (rst)
        ip_valid |=> (hit_vec & ~$past(insn_kind_mask)) == '0);

    // R8: an I/O hit resumes at the next instruction
    a_r8_io_resume: assert property (@(posedge clk) disable iff (rst)
        (!ip_valid && !d_valid && io_valid) |=>
            (!dbg_req || resume_ip == $past(next_ip)));
endmodule

bind bp_match_unit bp_match_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .ip       (ip),
    .ip_valid (ip_valid),
    .next_ip  (next_ip),
    .force_upd(force_upd),
    .d_valid  (d_valid),
    .io_valid (io_valid),
    .hit_vec  (hit_vec),
    .status_wr(status_wr),
    .dbg_req  (dbg_req),
    .resume_ip(resume_ip)
);

// File: tb/tb_bp_match_unit.sv
module tb_bp_match_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctrl = '0;
    logic [31:0] sa [4];
    logic [127:0] slot_addr;
    logic [31:0] ip = '0, next_ip = '0, d_addr = '0;
    logic        ip_valid = 0, force_upd = 0, d_write = 0, d_valid = 0, io_valid = 0;
    logic [3:0]  d_size = 4'd1;
    logic [15:0] io_port = '0;
    logic [2:0]  io_size = 3'd1;
    logic [3:0]  hit_vec;
    logic        status_wr, dbg_req;
    logic [31:0] resume_ip;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign slot_addr = {sa[3], sa[2], sa[1], sa[0]};

    bp_match_unit dut (
        .clk(clk), .rst(rst), .ctrl(ctrl), .slot_addr(slot_addr),
        .ip(ip), .ip_valid(ip_valid), .next_ip(next_ip), .force_upd(force_upd),
        .d_addr(d_addr), .d_size(d_size), .d_write(d_write), .d_valid(d_valid),
        .io_port(io_port), .io_size(io_size), .io_valid(io_valid),
        .hit_vec(hit_vec), .status_wr(status_wr), .dbg_req(dbg_req),
        .resume_ip(resume_ip)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // expected results computed from the requirement text
    task automatic model(output logic [3:0] eh, output logic ew, output logic ed,
                         output logic [31:0] er);
        logic [3:0] en;
        eh = '0; ew = 0; ed = 0; er = '0; en = '0;
        for (int i = 0; i < 4; i++) begin
            int ty, lc, ln;
            longint lo, hi;
            en[i] = ctrl[2*i] | ctrl[2*i+1];
            ty = int'(ctrl[16+4*i +: 2]);
            lc = int'(ctrl[18+4*i +: 2]);
            ln = (lc == 2) ? 8 : lc + 1;
            lo = longint'(sa[i]);
            hi = lo + ln - 1;
            if (ip_valid) begin
                if (ty == 0 && sa[i] == ip) eh[i] = 1;
            end else if (d_valid) begin
                if (((ty == 1 && d_write) || ty == 3) &&
                    longint'(d_addr) + d_size - 1 >= lo && longint'(d_addr) <= hi)
                    eh[i] = 1;
            end else if (io_valid) begin
                if (ty == 2 && en[i] &&
                    longint'(io_port) + io_size - 1 >= lo && longint'(io_port) <= hi)
                    eh[i] = 1;
            end
        end
        if (ip_valid || d_valid) begin
            ed = |(eh & en);
            ew = ed | force_upd;
            er = ip;
        end else if (io_valid) begin
            ed = |eh;
            ew = ed;
            er = ed ? next_ip : '0;
        end
    endtask

    // inputs are already set; clock once and compare all outputs
    task automatic step(input string tag);
        logic [3:0] eh; logic ew, ed; logic [31:0] er;
        model(eh, ew, ed, er);
        @(posedge clk); #1;
        chk({tag, " hit_vec"},   32'(hit_vec),   32'(eh));
        chk({tag, " status_wr"}, 32'(status_wr), 32'(ew));
        chk({tag, " dbg_req"},   32'(dbg_req),   32'(ed));
        chk({tag, " resume_ip"}, resume_ip,      er);
        @(negedge clk);
        ip_valid = 0; d_valid = 0; io_valid = 0; force_upd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) sa[i] = '0;
        ip_valid = 1; d_valid = 1; io_valid = 1; ctrl = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset holds outputs at zero despite valid inputs
        chk("R11 hit_vec", 32'(hit_vec), 0);
        chk("R11 status_wr", 32'(status_wr), 0);
        chk("R11 dbg_req", 32'(dbg_req), 0);
        chk("R11 resume_ip", resume_ip, 0);
        @(negedge clk);
        rst = 0; ip_valid = 0; d_valid = 0; io_valid = 0; ctrl = '0;

        // R9: idle cycle
        step("R9 idle");

        // R1: local-only, global-only and no enable on slot 1 (instruction kind)
        sa[1] = 32'h40; ip = 32'h40; next_ip = 32'h44;
        ctrl = 32'h0000_0004; ip_valid = 1; step("R1 local");
        ctrl = 32'h0000_0008; ip_valid = 1; step("R1 global");
        ctrl = 32'h0000_0000; ip_valid = 1;
        step("R7 disabled hit");
        // R7: disabled hit is recorded but raises nothing; force writes status
        ctrl = 32'h0000_0000; ip_valid = 1; force_upd = 1;
        step("R7 force");

        // R2/R3/R6: I/O slot 2 at port 0x100, each length code, edge ports
        sa[2] = 32'h100;
        for (int lc = 0; lc < 4; lc++) begin
            int ln;
            ln = (lc == 2) ? 8 : lc + 1;
            ctrl = 32'h0000_0010 | (32'h2 << 24) | (32'(lc) << 26);
            io_size = 3'd1; next_ip = 32'h900 + 32'(lc);
            io_port = 16'(32'h100 + ln - 1); io_valid = 1;
            step("R3 last byte");
            io_port = 16'(32'h100 + ln); io_valid = 1;
            step("R3 past end");
            io_port = 16'h0FE; io_size = 3'd2; io_valid = 1;
            step("R6 below");
            io_port = 16'h0FE; io_size = 3'd3; io_valid = 1;
            step("R8 overlap");
        end
        // R6: disabled I/O slot never hits
        ctrl = (32'h2 << 24); io_port = 16'h100; io_size = 3'd1; io_valid = 1;
        step("R6 disabled");

        // R5: data write slot versus read access
        sa[3] = 32'h200; ctrl = 32'h0000_0040 | (32'h1 << 28) | (32'h3 << 30);
        d_addr = 32'h1FE; d_size = 4'd4; d_write = 0; d_valid = 1;
        step("R5 read on write slot");
        d_write = 1; d_valid = 1;
        step("R5 write on write slot");

        // R10: all three classes at once
        ctrl = 32'hFFFF_00FF; ip = 32'h40; next_ip = 32'h77;
        ip_valid = 1; d_valid = 1; io_valid = 1;
        step("R10 all valid");
        chk("R10 resume is ip", resume_ip, 32'h40);
        ip_valid = 0; d_valid = 1; io_valid = 1; d_addr = 32'h200; d_write = 1;
        step("R10 data over io");

        // near-exhaustive random sweep in a narrow address window
        for (int n = 0; n < 3000; n++) begin
            ctrl = $urandom;
            for (int i = 0; i < 4; i++) sa[i] = 32'($urandom_range(0, 24));
            ip = 32'($urandom_range(0, 24));
            next_ip = $urandom;
            d_addr = 32'($urandom_range(0, 24));
            d_size = 4'($urandom_range(1, 8));
            d_write = 1'($urandom);
            io_port = 16'($urandom_range(0, 24));
            io_size = 3'($urandom_range(1, 4));
            ip_valid = 1'($urandom); d_valid = 1'($urandom);
            io_valid = 1'($urandom); force_upd = 1'($urandom);
            if (ip_valid)     step("R4 R7 sweep");
            else if (d_valid) step("R5 R7 sweep");
            else if (io_valid) step("R6 R8 sweep");
            else              step("R9 sweep");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule